// File: doc/BRIEF.md
# Receive Destination Address Filter

This block makes the accept or drop decision for each received Ethernet frame. The receive parser hands it the 48-bit destination address of a frame, together with a flag that marks the address as group (multicast). The block compares the address against a bank of programmable address slots and applies two mode bits: one accepts everything, and one admits every group-addressed frame. One cycle after a frame is taken in, the verdict appears as a registered accept bit, qualified by a valid signal.

Software programs the block through a plain register port. That port has a write strobe, an address and data, plus a combinational read path. One control word holds the mode bits. Each slot has a low word with address bytes 0 to 3, first-received byte in the least significant position. Each slot also has a high word with bytes 4 and 5 and the slot's enable flag. Slot 0 always takes part in matching. The other slots take part only when enabled, and only when the global filter enable is set.

Both streaming sides use valid/ready. An input is taken on a clock edge where `in_valid` and `in_ready` are both high. The output register holds one verdict. `in_ready` is high when that register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the verdict and `out_valid` hold steady and no new address is taken.

Top module: `da_filter`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and every register reads as zero.
- R2: The control word sits at byte offset 0x38 and keeps only bit 0 (accept all), bit 13 (filter enable) and bit 16 (accept group addresses); other bits read 0. The high word of slot n sits at 0x50+8n and keeps bit 31 (slot enable) and bits 15:0. The low word sits at 0x54+8n and keeps all 32 bits. Unmapped offsets read 0.
- R3: A slot matches when `in_da` equals {high[15:0], low[31:0]}. `in_da[7:0]` is the first address byte on the wire, so a byte-swapped address does not match.
- R4: Slot 0 takes part in matching whatever its enable bit and the filter enable are.
- R5: Slots 1 to 7 take part only when their high-word bit 31 is set and control bit 13 is set.
- R6: Writing zero to a slot's high word clears that slot's high word, enable flag and low word.
- R7: With control bit 0 set, every frame is accepted.
- R8: With control bit 16 set, every frame with `in_mcast` high is accepted.
- R9: A frame admitted by no mode bit and no participating slot is dropped (`out_accept` = 0).
- R10: The verdict for an address taken at edge k is presented with `out_valid` high after edge k. It is computed from the register contents in force before edge k, so a write in the same cycle does not affect it.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_accept` hold and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 8 | Register read byte offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | Destination address valid |
| in_ready | output | 1 | Block can take an address |
| in_da | input | 48 | Destination address, first byte in bits 7:0 |
| in_mcast | input | 1 | Address is a group address |
| out_valid | output | 1 | Verdict valid |
| out_ready | input | 1 | Consumer takes the verdict |
| out_accept | output | 1 | 1 = accept frame, 0 = drop |

## Verification
The bench targets several failure modes:
- A slot 1 address presented with only one of its two enabling bits set. A design that honours either bit alone would accept it.
- A zero high-word write. A design that clears only the high half would leave a stale low word that reads back nonzero.
- A register write issued in the same cycle as a frame. A design that looks at the new contents would flip that frame's verdict.
- A stalled output. A design without proper back-pressure would overwrite the held verdict or raise `in_ready`.
- A byte-swapped address, which exposes any reversed byte order in the compare.

Random traffic mixes hits, near-misses with one flipped bit, and mode changes.

// File: rtl/da_filt_pkg.sv
package da_filt_pkg;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 32;
  localparam int MAC_W       = 48;
  localparam int LO_W        = 32;
  localparam int HI_W        = MAC_W - LO_W;
  localparam int SLOT_STRIDE = 8;
  localparam int LO_OFS      = 4;

  localparam logic [ADDR_W-1:0] CTRL_OFS  = 8'h38;
  localparam logic [ADDR_W-1:0] SLOT_BASE = 8'h50;

  localparam int PROMISC_BIT = 0;
  localparam int FILT_EN_BIT = 13;
  localparam int ALL_MC_BIT  = 16;
  localparam int SLOT_EN_BIT = 31;

  typedef struct packed {
    logic all_mc;
    logic filt_en;
    logic promisc;
  } filt_ctrl_t;

  function automatic logic [ADDR_W-1:0] hi_ofs(input int n);
    return ADDR_W'(int'(SLOT_BASE) + n * SLOT_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] lo_ofs(input int n);
    return ADDR_W'(int'(SLOT_BASE) + n * SLOT_STRIDE + LO_OFS);
  endfunction
endpackage

// File: rtl/da_filt_regs.sv
module da_filt_regs
  import da_filt_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic [ADDR_W-1:0]                rd_addr,
  output logic [DATA_W-1:0]                rd_data,
  output filt_ctrl_t                       ctrl,
  output logic [NUM_SLOTS-1:0]             slot_en,
  output logic [NUM_SLOTS-1:0][HI_W-1:0]   slot_hi,
  output logic [NUM_SLOTS-1:0][LO_W-1:0]   slot_lo
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      slot_en <= '0;
      slot_hi <= '0;
      slot_lo <= '0;
    end else if (wr_en) begin
      if (wr_addr == CTRL_OFS) begin
        ctrl.promisc <= wr_data[PROMISC_BIT];
        ctrl.filt_en <= wr_data[FILT_EN_BIT];
        ctrl.all_mc  <= wr_data[ALL_MC_BIT];
      end
      for (int n = 0; n < NUM_SLOTS; n++) begin
        if (wr_addr == hi_ofs(n)) begin
          slot_en[n] <= wr_data[SLOT_EN_BIT];
          slot_hi[n] <= wr_data[HI_W-1:0];
          if (wr_data == '0) slot_lo[n] <= '0;
        end
        if (wr_addr == lo_ofs(n)) slot_lo[n] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_OFS) begin
      rd_data[PROMISC_BIT] = ctrl.promisc;
      rd_data[FILT_EN_BIT] = ctrl.filt_en;
      rd_data[ALL_MC_BIT]  = ctrl.all_mc;
    end
    for (int n = 0; n < NUM_SLOTS; n++) begin
      if (rd_addr == hi_ofs(n)) begin
        rd_data[SLOT_EN_BIT] = slot_en[n];
        rd_data[HI_W-1:0]    = slot_hi[n];
      end
      if (rd_addr == lo_ofs(n)) rd_data = slot_lo[n];
    end
  end

  // R2
  ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == CTRL_OFS) |=>
      (ctrl.promisc == $past(wr_data[PROMISC_BIT]) &&
       ctrl.filt_en == $past(wr_data[FILT_EN_BIT]) &&
       ctrl.all_mc  == $past(wr_data[ALL_MC_BIT])));

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot_chk
    // R6
    hi_zero_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == hi_ofs(g) && wr_data == '0) |=>
        (!slot_en[g] && slot_hi[g] == '0 && slot_lo[g] == '0));
  end

endmodule

// File: rtl/da_filt_slot_cmp.sv
module da_filt_slot_cmp
  import da_filt_pkg::*;
#(
  parameter bit ALWAYS_ON = 1'b0
) (
  input  logic [MAC_W-1:0] da,
  input  logic [HI_W-1:0]  hi,
  input  logic [LO_W-1:0]  lo,
  input  logic             en,
  input  logic             filt_en,
  output logic             hit
);
  logic addr_eq;
  logic gate;

  assign addr_eq = (da == {hi, lo});
  assign gate    = ALWAYS_ON | (en & filt_en);
  assign hit     = addr_eq & gate;
endmodule

// File: rtl/da_filt_decide.sv
module da_filt_decide
  import da_filt_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_mcast,
  input  logic [NUM_SLOTS-1:0] slot_hit,
  input  logic                 promisc,
  input  logic                 all_mc,
  input  logic                 out_ready,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic                 out_accept
);
  logic in_fire;
  logic verdict;

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;
  assign verdict  = promisc | (all_mc & in_mcast) | (|slot_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_accept <= 1'b0;
    end else if (in_fire) begin
      out_valid  <= 1'b1;
      out_accept <= verdict;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R10
  fire_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);

  // R11
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_accept)));

  // R7
  promisc_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && promisc) |=> out_accept);

  // R8
  all_mc_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && all_mc && in_mcast) |=> out_accept);

  // R9
  miss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !promisc && !(all_mc && in_mcast) && slot_hit == '0) |=> !out_accept);
endmodule

// File: rtl/da_filter.sv
module da_filter
  import da_filt_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MAC_W-1:0]  in_da,
  input  logic              in_mcast,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_accept
);
  filt_ctrl_t                     ctrl;
  logic [NUM_SLOTS-1:0]           slot_en;
  logic [NUM_SLOTS-1:0][HI_W-1:0] slot_hi;
  logic [NUM_SLOTS-1:0][LO_W-1:0] slot_lo;
  logic [NUM_SLOTS-1:0]           slot_hit;

  da_filt_regs #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .wr_data (reg_wr_data),
    .rd_addr (reg_rd_addr),
    .rd_data (reg_rd_data),
    .ctrl    (ctrl),
    .slot_en (slot_en),
    .slot_hi (slot_hi),
    .slot_lo (slot_lo)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    da_filt_slot_cmp #(.ALWAYS_ON(g == 0)) u_cmp (
      .da      (in_da),
      .hi      (slot_hi[g]),
      .lo      (slot_lo[g]),
      .en      (slot_en[g]),
      .filt_en (ctrl.filt_en),
      .hit     (slot_hit[g])
    );
    if (g > 0) begin : g_extra_chk
      // R5
      extra_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.filt_en || !slot_en[g]) |-> !slot_hit[g]);
    end
  end

  da_filt_decide #(.NUM_SLOTS(NUM_SLOTS)) u_decide (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_mcast   (in_mcast),
    .slot_hit   (slot_hit),
    .promisc    (ctrl.promisc),
    .all_mc     (ctrl.all_mc),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_accept (out_accept)
  );
endmodule

// File: tb/test_da_filter.sv
`timescale 1ns/1ps
module test_da_filter;
  import da_filt_pkg::*;

  localparam int  NS = 8;
  localparam real HALF = 2.5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr_en = 1'b0;
  logic [ADDR_W-1:0] reg_wr_addr = '0;
  logic [DATA_W-1:0] reg_wr_data = '0;
  logic [ADDR_W-1:0] reg_rd_addr = '0;
  logic [DATA_W-1:0] reg_rd_data;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [MAC_W-1:0]  in_da = '0;
  logic              in_mcast = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic              out_accept;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_ctrl;
  logic [15:0] m_hi [NS];
  logic        m_en [NS];
  logic [31:0] m_lo [NS];

  always #(HALF) clk = ~clk;

  da_filter #(.NUM_SLOTS(NS)) i_da_filter (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_da(in_da), .in_mcast(in_mcast),
    .out_valid(out_valid), .out_ready(out_ready), .out_accept(out_accept)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_accept(input logic [47:0] da, input logic mc);
    if (m_ctrl[0]) return 1'b1;
    if (m_ctrl[16] && mc) return 1'b1;
    for (int n = 0; n < NS; n++) begin
      if ((n == 0 || (m_ctrl[13] && m_en[n])) && da == {m_hi[n], m_lo[n]}) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic [31:0] mdl_read(input logic [7:0] a);
    logic [31:0] r = '0;
    if (a == 8'h38) r = m_ctrl;
    for (int n = 0; n < NS; n++) begin
      if (a == 8'(8'h50 + 8 * n)) r = {m_en[n], 15'b0, m_hi[n]};
      if (a == 8'(8'h54 + 8 * n)) r = m_lo[n];
    end
    return r;
  endfunction

  task automatic mdl_write(input logic [7:0] a, input logic [31:0] d);
    if (a == 8'h38) m_ctrl = d & 32'h0001_2001;
    for (int n = 0; n < NS; n++) begin
      if (a == 8'(8'h50 + 8 * n)) begin
        m_en[n] = d[31];
        m_hi[n] = d[15:0];
        if (d == 32'h0) m_lo[n] = '0;
      end
      if (a == 8'(8'h54 + 8 * n)) m_lo[n] = d;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    mdl_write(a, d);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input string req);
    logic [31:0] e;
    @(negedge clk);
    reg_rd_addr = a;
    #1;
    e = mdl_read(a);
    check(reg_rd_data === e, req, 64'(reg_rd_data), 64'(e));
  endtask

  task automatic send_frame(input logic [47:0] da, input logic mc, input string req);
    bit e;
    @(negedge clk);
    in_valid = 1'b1; in_da = da; in_mcast = mc;
    e = exp_accept(da, mc);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_accept === e, req,
          64'({out_valid, out_accept}), 64'({1'b1, e}));
  endtask

  initial begin
    #(2.0 * HALF * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog R10: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [47:0] s0;
    logic [47:0] da;
    void'($urandom(32'd7311));
    m_ctrl = '0;
    for (int n = 0; n < NS; n++) begin m_hi[n] = '0; m_en[n] = 1'b0; m_lo[n] = '0; end

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(out_valid === 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    check(in_ready === 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
    rd_check(8'h38, "R1 ctrl");
    rd_check(8'h50, "R1 slot0 hi");
    rd_check(8'h6C, "R1 slot3 lo");

    // R4: slot 0 is zero after reset and matches the zero address
    send_frame(48'h0, 1'b0, "R4 zero addr");
    send_frame(48'h1, 1'b1, "R9 unmatched");

    // R3: byte order
    wr(8'h54, 32'h4433_2211);
    wr(8'h50, 32'h0000_6655);
    send_frame(48'h6655_4433_2211, 1'b1, "R3 slot0 hit");
    send_frame(48'h1122_3344_5566, 1'b0, "R3 swapped miss");

    // R5: slot 1 needs both enable bits
    wr(8'h5C, 32'hAABB_CCDD);
    wr(8'h58, 32'h0000_EEFF);
    send_frame(48'hEEFF_AABB_CCDD, 1'b1, "R5 no enables");
    wr(8'h38, 32'h0000_2000);
    send_frame(48'hEEFF_AABB_CCDD, 1'b1, "R5 filt only");
    wr(8'h58, 32'h8000_EEFF);
    send_frame(48'hEEFF_AABB_CCDD, 1'b1, "R5 both set");
    wr(8'h38, 32'h0000_0000);
    send_frame(48'hEEFF_AABB_CCDD, 1'b1, "R5 slot en only");
    wr(8'h38, 32'h0000_2000);

    // R6
    wr(8'h58, 32'h0);
    rd_check(8'h5C, "R6 lo cleared");
    rd_check(8'h58, "R6 hi cleared");
    send_frame(48'hEEFF_AABB_CCDD, 1'b1, "R6 old addr dropped");
    send_frame(48'h0, 1'b0, "R6 zero addr dropped");

    // R7
    wr(8'h38, 32'h0000_2001);
    send_frame(48'h1234_5678_9ABC, 1'b0, "R7 promisc");
    wr(8'h38, 32'h0000_2000);

    // R8
    send_frame(48'h7777_0000_0001, 1'b1, "R8 mc off");
    wr(8'h38, 32'h0001_2000);
    send_frame(48'h7777_0000_0001, 1'b1, "R8 mc on");
    send_frame(48'h7777_0000_0002, 1'b0, "R8 unicast miss");
    wr(8'h38, 32'h0000_2000);

    // R2
    wr(8'h38, 32'hFFFF_FFFF);
    rd_check(8'h38, "R2 ctrl mask");
    rd_check(8'h3C, "R2 unmapped");
    wr(8'h70, 32'h7FFF_1234);
    rd_check(8'h70, "R2 hi mask");
    rd_check(8'h8C, "R2 slot7 lo");
    wr(8'h38, 32'h0000_2000);

    // R10: write in same cycle as a frame uses old contents
    s0 = {m_hi[0], m_lo[0]};
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = 8'h54; reg_wr_data = 32'hDEAD_0000;
    in_valid = 1'b1; in_da = s0; in_mcast = s0[0];
    check(exp_accept(s0, s0[0]) == 1'b1, "R10 setup", 64'(0), 64'd1);
    mdl_write(8'h54, 32'hDEAD_0000);
    @(negedge clk);
    reg_wr_en = 1'b0; in_valid = 1'b0;
    check(out_valid === 1'b1 && out_accept === 1'b1, "R10 old contents",
          64'({out_valid, out_accept}), 64'b11);
    @(negedge clk);
    check(out_valid === 1'b0, "R10 pulse ends", 64'(out_valid), 64'd0);
    send_frame(s0, s0[0], "R10 new contents");

    // R11: back-pressure
    s0 = {m_hi[0], m_lo[0]};
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_da = s0; in_mcast = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_accept === 1'b1, "R11 first verdict",
          64'({out_valid, out_accept}), 64'b11);
    @(negedge clk);
    @(negedge clk);
    check(out_valid === 1'b1 && out_accept === 1'b1, "R11 held",
          64'({out_valid, out_accept}), 64'b11);
    in_valid = 1'b1; in_da = 48'h0BAD_0BAD_0BAD; in_mcast = 1'b0;
    #1;
    check(in_ready === 1'b0, "R11 in_ready low", 64'(in_ready), 64'd0);
    @(negedge clk);
    check(out_valid === 1'b1 && out_accept === 1'b1, "R11 not overwritten",
          64'({out_valid, out_accept}), 64'b11);
    out_ready = 1'b1;
    #1;
    check(in_ready === 1'b1, "R11 in_ready on pop", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_accept === 1'b0, "R11 second verdict",
          64'({out_valid, out_accept}), 64'b10);

    // random traffic
    for (int it = 0; it < 400; it++) begin
      int sel;
      int n;
      logic [31:0] d;
      sel = int'($urandom_range(0, 9));
      n = int'($urandom_range(0, NS - 1));
      case (sel)
        0, 1: begin
          case ($urandom_range(0, 2))
            0: wr(hi_ofs(n), $urandom);
            1: wr(lo_ofs(n), $urandom);
            default: wr(hi_ofs(n), 32'h0);
          endcase
        end
        2: begin
          d = $urandom;
          d[0] = ($urandom_range(0, 7) == 0);
          wr(8'h38, d);
        end
        3: rd_check(($urandom_range(0, 1) == 0) ? hi_ofs(n) : lo_ofs(n), "R2 random read");
        default: begin
          if ($urandom_range(0, 1) == 0) da = {m_hi[n], m_lo[n]};
          else da = {$urandom, $urandom};
          if ($urandom_range(0, 3) == 0) da[$urandom_range(0, 47)] ^= 1'b1;
          send_frame(da, da[0], "R3 R4 R5 R7 R8 R9 random");
        end
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule